// File: doc/BRIEF.md
# Multi-Owner Hardware Lock Bank

This block holds a bank of independent hardware locks that several processors use to arbitrate access to shared resources. It sits behind one simple register-bus slave port and exposes one 32-bit word per lock. A master claims a lock by writing its own nonzero owner tag into that lock's word. It then reads the word back. It holds the lock only if the returned tag equals its own. Any write whose tag field is zero frees the lock.

The claim is decided entirely inside the bank in the cycle of the write. A free lock takes the tag that is written. A lock that is already held keeps its owner, whatever tag is written. Reads have one cycle of latency and never change lock state. The bank therefore gives masters an atomic claim without a read-to-set access.

Top module: `lockbank_top`

## Requirements
- R1: After a synchronous reset every lock is free, and a read of any lock word returns 0. `rd_data` is also 0 after reset.
- R2: A write with a nonzero tag to a free lock stores the tag. The tag is `wr_data[3:0]`, so any value 1 to 15 can be stored. A later read of that lock returns the tag.
- R3: A write with a nonzero tag to a lock held under a different tag is ignored, and the stored owner stays unchanged.
- R4: A write of the holder's own tag to a lock it holds leaves the lock unchanged.
- R5: A write whose `wr_data[3:0]` is zero releases the lock, whatever its upper bits are. A released lock can then be claimed by any tag.
- R6: Write data bits 31:4 are ignored, and bits 31:4 of every read word are zero.
- R7: `rd_data` is loaded on the rising edge that samples `rd_en` high, so it shows the addressed lock's owner one cycle after the request. While `rd_en` is low, `rd_data` holds its last value.
- R8: A read has no effect on lock state. A read and a write to the same lock in one cycle return the owner as it was before that write.
- R9: Lock n is selected by `addr[7:2]` = n, which is byte offset 4*n, and `addr[1:0]` are ignored. A write changes only the selected lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address shared by reads and writes; bits 7:2 select the lock |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write word; bits 3:0 are the owner tag, and 0 means release |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Registered read word; bits 3:0 are the owner, and the rest are zero |

## Verification
The assertions take for granted that at most one write reaches the bank per cycle, which is inherent to the single port. They also take for granted that the strobes and address carry defined values from the first edge after reset. Under those conditions each lock cell's assertions check the claim, ignore and release rules, and the read port's assertions check the zero upper bits and the hold behaviour. The bench drives every input on the falling edge with defined values. It sweeps every lock index with every nonzero tag value and with nonzero low address bits. It compares each read word against a model that applies the claim and release rules arithmetically.

// File: rtl/lkb_pkg.sv
`timescale 1ns/1ps
package lkb_pkg;
  localparam int unsigned LKB_TAG_W = 4;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_CLAIM   = 2'd1,
    OP_RELEASE = 2'd2
  } lkb_op_e;
endpackage

// File: rtl/lkb_decode.sv
`timescale 1ns/1ps
module lkb_decode
  import lkb_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 64,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TAG_W     = LKB_TAG_W,
  parameter int unsigned IDX_W     = $clog2(NUM_LOCKS),
  parameter int unsigned ADDR_W    = IDX_W + 2
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [NUM_LOCKS-1:0] sel,
  output lkb_op_e              op,
  output logic [TAG_W-1:0]     tag
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_LOCKS);

  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic             unused_bits;

  assign idx         = addr[ADDR_W-1:2];
  assign in_range    = {1'b0, idx} < LIMIT;
  assign tag         = wr_data[TAG_W-1:0];
  assign unused_bits = ^{addr[1:0], wr_data[DATA_W-1:TAG_W]};

  always_comb begin
    if (!wr_en)            op = OP_NONE;
    else if (tag != '0)    op = OP_CLAIM;
    else                   op = OP_RELEASE;
  end

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_sel
    assign sel[i] = wr_en && in_range && (idx == IDX_W'(i));
  end

  always_comb begin
    assert_one_target_R9: assert ($onehot0(sel) || $isunknown(sel))
      else $error("more than one lock selected");
  end
endmodule

// File: rtl/lkb_cell.sv
`timescale 1ns/1ps
module lkb_cell
  import lkb_pkg::*;
#(
  parameter int unsigned TAG_W = LKB_TAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  lkb_op_e          op,
  input  logic [TAG_W-1:0] tag,
  output logic [TAG_W-1:0] owner
);
  always_ff @(posedge clk) begin
    if (rst) begin
      owner <= '0;
    end else if (sel) begin
      case (op)
        OP_CLAIM:   if (owner == '0) owner <= tag;
        OP_RELEASE: owner <= '0;
        default:    owner <= owner;
      endcase
    end
  end

  assert_claim_free_R2: assert property (@(posedge clk) disable iff (rst)
    (sel && op == OP_CLAIM && owner == '0) |=> (owner == $past(tag)))
    else $error("free lock did not take the tag");

  assert_held_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    (sel && op == OP_CLAIM && owner != '0) |=> $stable(owner))
    else $error("held lock changed owner on a claim");

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (sel && op == OP_RELEASE) |=> (owner == '0))
    else $error("release did not free the lock");

  assert_untouched_R9: assert property (@(posedge clk) disable iff (rst)
    (!sel) |=> $stable(owner))
    else $error("unselected lock changed");
endmodule

// File: rtl/lkb_rdport.sv
`timescale 1ns/1ps
module lkb_rdport #(
  parameter int unsigned NUM_LOCKS = 64,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TAG_W     = 4,
  parameter int unsigned IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd_en,
  input  logic [IDX_W-1:0]                 rd_idx,
  input  logic [NUM_LOCKS-1:0][TAG_W-1:0]  owners,
  output logic [DATA_W-1:0]                rd_data
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_LOCKS);

  logic             in_range;
  logic [TAG_W-1:0] picked;

  assign in_range = {1'b0, rd_idx} < LIMIT;
  assign picked   = in_range ? owners[rd_idx] : '0;

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= DATA_W'(picked);
  end

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data[DATA_W-1:TAG_W] == '0))
    else $error("upper read bits not zero");

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!rd_en) |=> $stable(rd_data))
    else $error("read data changed without a request");
endmodule

// File: rtl/lockbank_top.sv
`timescale 1ns/1ps
module lockbank_top
  import lkb_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 64,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TAG_W     = LKB_TAG_W,
  parameter int unsigned IDX_W     = $clog2(NUM_LOCKS),
  parameter int unsigned ADDR_W    = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  logic [NUM_LOCKS-1:0]             sel;
  lkb_op_e                          op;
  logic [TAG_W-1:0]                 tag;
  logic [NUM_LOCKS-1:0][TAG_W-1:0]  owners;

  lkb_decode #(
    .NUM_LOCKS(NUM_LOCKS), .DATA_W(DATA_W), .TAG_W(TAG_W),
    .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .sel(sel), .op(op), .tag(tag)
  );

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    lkb_cell #(.TAG_W(TAG_W)) u_cell (
      .clk(clk), .rst(rst), .sel(sel[i]), .op(op), .tag(tag),
      .owner(owners[i])
    );
  end

  lkb_rdport #(
    .NUM_LOCKS(NUM_LOCKS), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)
  ) u_rdport (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_idx(addr[ADDR_W-1:2]),
    .owners(owners), .rd_data(rd_data)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0))
    else $error("read data not cleared by reset");
endmodule

// File: tb/tb_lockbank_top.sv
`timescale 1ns/1ps
module tb_lockbank_top;
  localparam int N  = 64;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] model [N];

  always #2.5 clk = ~clk;

  lockbank_top dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void apply(input int idx, input logic [31:0] d);
    if (d[3:0] == 4'd0)      model[idx] = 4'd0;
    else if (model[idx] == 0) model[idx] = d[3:0];
  endfunction

  task automatic wr(input int idx, input int lo, input logic [31:0] d);
    @(negedge clk);
    addr = AW'(idx * 4 + lo); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    apply(idx, d);
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk);
    addr = AW'(idx * 4 + (idx % 4)); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int i = 0; i < N; i++) begin
      rd(i, v);
      check(req, v, {28'd0, model[i]});
    end
  endtask

  function automatic logic [3:0] tag_a(input int i);
    return 4'((i % 15) + 1);
  endfunction

  function automatic logic [3:0] tag_b(input int i);
    return 4'((tag_a(i) % 15) + 1);
  endfunction

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < N; i++) model[i] = 4'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rd_data after reset", rd_data, 32'd0);
    check_all("R1 all free");

    // R2, R6, R9: claim every lock with junk upper bits and unaligned low address bits
    for (int i = 0; i < N; i++) begin
      wr(i, i % 4, {28'hDEADBEE, tag_a(i)});
      if (i + 1 < N) begin
        rd(i + 1, v);
        check("R9 neighbour untouched", v, 32'd0);
      end
    end
    check_all("R2/R6 claimed tags");

    // R3: a different tag on a held lock is ignored
    for (int i = 0; i < N; i++) begin
      wr(i, 0, {28'h5A5A5A5, tag_b(i)});
      rd(i, v);
      check("R3 foreign claim ignored", v, {28'd0, tag_a(i)});
    end

    // R4: the holder writing its own tag again
    for (int i = 0; i < N; i += 7) begin
      wr(i, 3, {28'h0000001, tag_a(i)});
      rd(i, v);
      check("R4 reclaim unchanged", v, {28'd0, tag_a(i)});
    end

    // R5, R6: release with junk upper bits on even locks, plain zero on odd ones
    for (int i = 0; i < N; i++)
      wr(i, 1, (i % 2 == 0) ? 32'hFFFF_FFF0 : 32'd0);
    check_all("R5 released");

    for (int i = 0; i < 4; i++) begin
      wr(i, 0, 32'd7);
      rd(i, v);
      check("R5 reclaim after release", v, 32'd7);
    end

    // R8: a read and a write in the same cycle return the old owner
    @(negedge clk);
    addr = AW'(10 * 4); wr_data = 32'd3; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    apply(10, 32'd3);
    check("R8 same-cycle read sees old owner", rd_data, 32'd0);
    for (int k = 0; k < 5; k++) begin
      rd(10, v);
      check("R8 repeated reads no side effect", v, 32'd3);
    end

    // R7: hold while idle, then one cycle of latency
    @(negedge clk);
    addr = 8'd0;
    repeat (4) @(negedge clk);
    check("R7 hold while idle", rd_data, 32'd3);
    rd_en = 1'b1;
    #1;
    check("R7 no zero-latency change", rd_data, 32'd3);
    @(negedge clk);
    rd_en = 1'b0;
    check("R7 one-cycle latency", rd_data, 32'd7);

    // R1: reset in the middle of operation
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) model[i] = 4'd0;
    check("R1 rd_data after second reset", rd_data, 32'd0);
    check_all("R1 all free after second reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule